// File: doc/BRIEF.md
# Ethernet PHY Link Bring-Up Sequencer

This block brings a 10/100 Ethernet PHY from power-on to a known link state without software. A single-cycle start pulse, together with a PHY address, launches a fixed series of management-register transactions. The block first soft-resets the PHY and polls until the reset has finished. It then advertises every 10/100 half- and full-duplex ability, enables and restarts auto-negotiation, and polls until negotiation completes. A last status read decides the speed and the duplex mode.

The transactions go to an MDIO master through a one-outstanding request/acknowledge interface. A request carries a write flag, a PHY address, a register number and write data. It stays asserted, with every field held steady, until the master returns a one-cycle done pulse; for a read, the data arrives with that pulse. Polls are bounded: a parameterised gap of clock cycles separates two polls, and each polling phase has its own retry limit. Running out of retries in a phase stops the sequence and raises the error flag that belongs to that phase.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, `busy`, `link_ok`, `speed_100`, `full_duplex`, both error flags and `req_valid` are all 0.
- R2: The first request after an accepted start is a write (`req_write`=1) to register 0 of the latched PHY address with data 0x8000.
- R3: The block then reads register 0 until bit 15 of the returned data is 0. At least WAIT_CYC clock cycles pass between the done of a failed poll and the next poll request.
- R4: If RESET_TRIES reads of register 0 all return bit 15 set, `err_reset_timeout` rises in the same cycle that `busy` falls, and no further request is issued. The two error flags are never set together.
- R5: Once reset has cleared, the block writes register 4 with 0x01E1.
- R6: Next, the block writes register 0 with 0x1200.
- R7: The block then reads register 1 until bit 5 is set. If ANEG_TRIES reads all return bit 5 clear, `err_aneg_timeout` rises, `busy` falls and no further request is issued.
- R8: After negedness completes, one more read of register 1 is issued. `speed_100` is set to bit 14 OR bit 13 of that read's data, and the poll reads do not affect it.
- R9: `full_duplex` is set to bit 14 OR bit 12 of that final read. `link_ok` rises and `busy` falls in the same cycle, and `link_ok` is never 1 while an error flag is set.
- R10: At most one request is outstanding. `req_valid` and all request fields stay constant until `rsp_done` arrives, and an `rsp_done` that arrives while `req_valid` is 0 has no effect.
- R11: A start pulse while `busy` is 1 is ignored. A start pulse while idle clears both error flags, `link_ok`, `speed_100` and `full_duplex` in the next cycle.
- R12: While idle, `link_ok`, `speed_100` and `full_duplex` keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to begin bring-up |
| phy_addr | input | ADDR_W | PHY address, latched at start |
| req_valid | output | 1 | Register transaction requested |
| req_write | output | 1 | 1 = write, 0 = read |
| req_phy | output | ADDR_W | PHY address of the request |
| req_reg | output | 5 | Register number of the request |
| req_wdata | output | 16 | Write data |
| rsp_done | input | 1 | Transaction finished (one cycle) |
| rsp_rdata | input | 16 | Read data, valid with rsp_done |
| busy | output | 1 | Sequence in progress |
| link_ok | output | 1 | Bring-up completed successfully |
| speed_100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | output | 1 | Full-duplex link |
| err_reset_timeout | output | 1 | PHY reset never cleared |
| err_aneg_timeout | output | 1 | Negotiation never completed |

## Verification
The conditions hardest to reach from the ports are the retry limits. These are the exact poll on which a phase either succeeds at the last permitted attempt or times out one attempt later. The bench PHY responder is scripted with a count of "still busy" answers per phase. That count is set to one below the limit and to exactly the limit, for both the reset phase and the negotiation phase. The poll answers carry ability bits that differ from the final status word, so a decode taken from the wrong read shows up as a wrong speed or duplex.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

  localparam int REG_W  = 5;
  localparam int DATA_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_WR,
    ST_RST_RD,
    ST_RST_GAP,
    ST_ADV_WR,
    ST_CTL_WR,
    ST_NEG_RD,
    ST_NEG_GAP,
    ST_STAT_RD
  } seq_state_e;

  localparam logic [REG_W-1:0] REG_CTRL = 5'd0;
  localparam logic [REG_W-1:0] REG_STAT = 5'd1;
  localparam logic [REG_W-1:0] REG_ADV  = 5'd4;

  localparam logic [DATA_W-1:0] CTRL_SOFT_RESET = 16'h8000;
  localparam logic [DATA_W-1:0] CTRL_ANEG_GO    = 16'h1000 | 16'h0200;

  // advertisement word: 100FD, 100HD, 10FD, 10HD, selector = 1
  function automatic logic [DATA_W-1:0] adv_word();
    logic [DATA_W-1:0] w;
    w = '0;
    w[8] = 1'b1;
    w[7] = 1'b1;
    w[6] = 1'b1;
    w[5] = 1'b1;
    w[0] = 1'b1;
    return w;
  endfunction

  function automatic logic reset_pending(input logic [DATA_W-1:0] d);
    return d[15];
  endfunction

  function automatic logic aneg_complete(input logic [DATA_W-1:0] d);
    return d[5];
  endfunction

  function automatic logic pick_100(input logic [DATA_W-1:0] d);
    return d[14] | d[13];
  endfunction

  function automatic logic pick_full(input logic [DATA_W-1:0] d);
    return d[14] | d[12];
  endfunction

endpackage

// File: rtl/bringup_mdio_port.sv
module bringup_mdio_port
  import phy_bringup_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              issue_write,
  input  logic [ADDR_W-1:0] issue_phy,
  input  logic [REG_W-1:0]  issue_reg,
  input  logic [DATA_W-1:0] issue_wdata,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_phy,
  output logic [REG_W-1:0]  req_reg,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_done,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              xfer_done,
  output logic [DATA_W-1:0] xfer_data
);

  assign xfer_done = req_valid & rsp_done;
  assign xfer_data = rsp_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_phy   <= '0;
      req_reg   <= '0;
      req_wdata <= '0;
    end else if (issue) begin
      req_valid <= 1'b1;
      req_write <= issue_write;
      req_phy   <= issue_phy;
      req_reg   <= issue_reg;
      req_wdata <= issue_wdata;
    end else if (xfer_done) begin
      req_valid <= 1'b0;
    end
  end

  // R10: a new request never overlaps an outstanding one
  p_single_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !req_valid);

  // R10: request held unchanged until acknowledged
  p_fields_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_done) |=> (req_valid && $stable(req_write) &&
      $stable(req_phy) && $stable(req_reg) && $stable(req_wdata)));

endmodule

// File: rtl/bringup_gap_timer.sv
module bringup_gap_timer #(
  parameter int WAIT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  localparam int CW = $clog2(WAIT_CYC + 1) + 1;

  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= CW'(WAIT_CYC);
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  initial begin
    p_wait_positive_r3: assert (WAIT_CYC >= 1);
  end

endmodule

// File: rtl/bringup_retry_count.sv
module bringup_retry_count #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic last
);

  localparam int CW = $clog2(LIMIT + 1) + 1;

  logic [CW-1:0] cnt;

  assign last = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (bump)  cnt <= cnt + CW'(1);
  end

  // R3/R7: attempt count never passes the limit
  p_retry_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT));

  // a bump is never requested on the final allowed attempt
  p_no_bump_at_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !clr) |-> !last);

endmodule

// File: rtl/bringup_link_decode.sv
module bringup_link_decode
  import phy_bringup_pkg::*;
(
  input  logic [DATA_W-1:0] stat,
  output logic              is_100,
  output logic              is_full
);

  assign is_100  = pick_100(stat);
  assign is_full = pick_full(stat);

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_bringup_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int WAIT_CYC    = 1000,
  parameter int RESET_TRIES = 10,
  parameter int ANEG_TRIES  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] phy_addr,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_phy,
  output logic [4:0]        req_reg,
  output logic [15:0]       req_wdata,
  input  logic              rsp_done,
  input  logic [15:0]       rsp_rdata,
  output logic              busy,
  output logic              link_ok,
  output logic              speed_100,
  output logic              full_duplex,
  output logic              err_reset_timeout,
  output logic              err_aneg_timeout
);

  seq_state_e        st;
  logic [ADDR_W-1:0] addr_q;
  logic              launched;

  // named internal events
  logic              issue;
  logic              is_issue_state;
  logic              start_ok;
  logic              xfer_done;
  logic [DATA_W-1:0] xfer_data;
  logic              rst_poll_fail;
  logic              neg_poll_fail;
  logic              rst_last;
  logic              neg_last;
  logic              gap_expired;
  logic              gap_load;
  logic              dec_100;
  logic              dec_full;

  logic              nxt_write;
  logic [REG_W-1:0]  nxt_reg;
  logic [DATA_W-1:0] nxt_wdata;

  assign busy           = (st != ST_IDLE);
  assign start_ok       = (st == ST_IDLE) && start;
  assign is_issue_state = (st == ST_RST_WR) || (st == ST_RST_RD) || (st == ST_ADV_WR) ||
                          (st == ST_CTL_WR) || (st == ST_NEG_RD) || (st == ST_STAT_RD);
  assign issue          = is_issue_state && !launched;

  assign rst_poll_fail  = (st == ST_RST_RD) && xfer_done && reset_pending(xfer_data);
  assign neg_poll_fail  = (st == ST_NEG_RD) && xfer_done && !aneg_complete(xfer_data);
  assign gap_load       = (rst_poll_fail && !rst_last) || (neg_poll_fail && !neg_last);

  always_comb begin
    nxt_write = 1'b0;
    nxt_reg   = REG_CTRL;
    nxt_wdata = '0;
    case (st)
      ST_RST_WR: begin
        nxt_write = 1'b1;
        nxt_wdata = CTRL_SOFT_RESET;
      end
      ST_ADV_WR: begin
        nxt_write = 1'b1;
        nxt_reg   = REG_ADV;
        nxt_wdata = adv_word();
      end
      ST_CTL_WR: begin
        nxt_write = 1'b1;
        nxt_wdata = CTRL_ANEG_GO;
      end
      ST_NEG_RD, ST_STAT_RD: nxt_reg = REG_STAT;
      default: ;
    endcase
  end

  bringup_mdio_port #(.ADDR_W(ADDR_W)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (issue),
    .issue_write (nxt_write),
    .issue_phy   (addr_q),
    .issue_reg   (nxt_reg),
    .issue_wdata (nxt_wdata),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_phy     (req_phy),
    .req_reg     (req_reg),
    .req_wdata   (req_wdata),
    .rsp_done    (rsp_done),
    .rsp_rdata   (rsp_rdata),
    .xfer_done   (xfer_done),
    .xfer_data   (xfer_data)
  );

  bringup_gap_timer #(.WAIT_CYC(WAIT_CYC)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .expired (gap_expired)
  );

  bringup_retry_count #(.LIMIT(RESET_TRIES)) u_rst_tries (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_ok),
    .bump  (rst_poll_fail && !rst_last),
    .last  (rst_last)
  );

  bringup_retry_count #(.LIMIT(ANEG_TRIES)) u_neg_tries (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_ok),
    .bump  (neg_poll_fail && !neg_last),
    .last  (neg_last)
  );

  bringup_link_decode u_dec (
    .stat    (xfer_data),
    .is_100  (dec_100),
    .is_full (dec_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          launched <= 1'b0;
    else if (issue)      launched <= 1'b1;
    else if (xfer_done)  launched <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st                <= ST_IDLE;
      addr_q            <= '0;
      link_ok           <= 1'b0;
      speed_100         <= 1'b0;
      full_duplex       <= 1'b0;
      err_reset_timeout <= 1'b0;
      err_aneg_timeout  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st                <= ST_RST_WR;
          addr_q            <= phy_addr;
          link_ok           <= 1'b0;
          speed_100         <= 1'b0;
          full_duplex       <= 1'b0;
          err_reset_timeout <= 1'b0;
          err_aneg_timeout  <= 1'b0;
        end
        ST_RST_WR: if (xfer_done) st <= ST_RST_RD;
        ST_RST_RD: if (xfer_done) begin
          if (!reset_pending(xfer_data)) st <= ST_ADV_WR;
          else if (rst_last) begin
            err_reset_timeout <= 1'b1;
            st                <= ST_IDLE;
          end else st <= ST_RST_GAP;
        end
        ST_RST_GAP: if (gap_expired) st <= ST_RST_RD;
        ST_ADV_WR:  if (xfer_done) st <= ST_CTL_WR;
        ST_CTL_WR:  if (xfer_done) st <= ST_NEG_RD;
        ST_NEG_RD: if (xfer_done) begin
          if (aneg_complete(xfer_data)) st <= ST_STAT_RD;
          else if (neg_last) begin
            err_aneg_timeout <= 1'b1;
            st               <= ST_IDLE;
          end else st <= ST_NEG_GAP;
        end
        ST_NEG_GAP: if (gap_expired) st <= ST_NEG_RD;
        ST_STAT_RD: if (xfer_done) begin
          link_ok     <= 1'b1;
          speed_100   <= dec_100;
          full_duplex <= dec_full;
          st          <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4/R7: error flags are exclusive
  p_err_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_reset_timeout && err_aneg_timeout));

  // R9: success never coexists with an error
  p_ok_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    link_ok |-> (!err_reset_timeout && !err_aneg_timeout));

  // R8: a speed result only exists with a successful link
  p_speed_needs_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_100 || full_duplex) |-> link_ok);

  // R11: accepted start clears results and errors
  p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !link_ok && !err_reset_timeout && !err_aneg_timeout));

  // R12: idle results hold without a start
  p_hold_results_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(link_ok) && $stable(speed_100) && $stable(full_duplex)));

  // R4: no bus activity when idle
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  // R3: the gap between polls is silent on the bus
  p_gap_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_RST_GAP) || (st == ST_NEG_GAP)) |-> !req_valid);

endmodule

// File: tb/sim_phy_bringup_seq.sv
module sim_phy_bringup_seq;

  localparam int WAIT = 6;
  localparam int RT   = 10;
  localparam int NT   = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic        req_valid, req_write;
  logic [4:0]  req_phy, req_reg;
  logic [15:0] req_wdata;
  logic        rsp_done = 1'b0;
  logic [15:0] rsp_rdata = '0;
  logic        busy, link_ok, speed_100, full_duplex, err_r, err_n;

  always #4 clk = ~clk;

  phy_bringup_seq #(.ADDR_W(5), .WAIT_CYC(WAIT), .RESET_TRIES(RT), .ANEG_TRIES(NT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .phy_addr(phy_addr),
    .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
    .req_reg(req_reg), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .busy(busy), .link_ok(link_ok), .speed_100(speed_100),
    .full_duplex(full_duplex), .err_reset_timeout(err_r), .err_aneg_timeout(err_n));

  int nvec = 0, nbad = 0;

  // reference model: committed (m_) and next (n_) expected outputs
  bit m_busy, m_ok, m_100, m_full, m_er, m_en;
  bit n_busy, n_ok, n_100, n_full, n_er, n_en;

  logic [26:0] exp_q[$];
  logic [26:0] cur;
  logic [4:0]  cur_addr;
  int  cyc = 0, lat = 0, rd0_n = 0, rd1_n = 0, last_done_cyc = 0;
  int  sc_rb = 0, sc_np = 0;
  logic [15:0] sc_fin = '0;
  bit  act = 0, neg_ok = 0, gap_due = 0, go = 0, spur = 0;

  task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    nvec++;
    if (act_v !== exp_v) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act_v, exp_v, cyc);
    end
  endtask

  function automatic logic [26:0] pack(input bit wr, input logic [4:0] a,
                                       input logic [4:0] rg, input logic [15:0] d);
    return {wr, a, rg, (wr ? d : 16'h0)};
  endfunction

  task automatic build_queue();
    int nr;
    exp_q.delete();
    exp_q.push_back(pack(1, cur_addr, 5'd0, 16'h8000));
    nr = (sc_rb + 1 < RT) ? sc_rb + 1 : RT;
    for (int i = 0; i < nr; i++) exp_q.push_back(pack(0, cur_addr, 5'd0, 16'h0));
    if (sc_rb < RT) begin
      exp_q.push_back(pack(1, cur_addr, 5'd4, 16'h01E1));
      exp_q.push_back(pack(1, cur_addr, 5'd0, 16'h1200));
      nr = (sc_np + 1 < NT) ? sc_np + 1 : NT;
      for (int i = 0; i < nr; i++) exp_q.push_back(pack(0, cur_addr, 5'd1, 16'h0));
      if (sc_np < NT) exp_q.push_back(pack(0, cur_addr, 5'd1, 16'h0));
    end
  endtask

  task automatic step();
    logic [26:0] e;
    logic [26:0] seen;
    logic [15:0] d;
    bit prev_done;
    string t;
    @(negedge clk);
    cyc++;
    {m_busy, m_ok, m_100, m_full, m_er, m_en} = {n_busy, n_ok, n_100, n_full, n_er, n_en};
    // R1 R4 R7 R8 R9 R11 R12: every-clock output comparison
    chk("R8/R9/R12 outputs {busy,ok,100,full,err_rst,err_neg}",
        {26'd0, busy, link_ok, speed_100, full_duplex, err_r, err_n},
        {26'd0, m_busy, m_ok, m_100, m_full, m_er, m_en});
    prev_done = rsp_done;
    rsp_done  = spur;
    rsp_rdata = spur ? 16'hFFFF : 16'h0;
    start     = go;
    if (go && !m_busy) begin
      n_busy = 1; n_ok = 0; n_100 = 0; n_full = 0; n_er = 0; n_en = 0;
      rd0_n = 0; rd1_n = 0; neg_ok = 0; gap_due = 0;
      cur_addr = phy_addr;
      build_queue();
    end
    seen = {req_write, req_phy, req_reg, (req_write ? req_wdata : 16'h0)};
    if (!act && req_valid && !prev_done && !spur) begin
      if (exp_q.size() == 0) chk("R4 unexpected request", 32'd1, 32'd0);
      else begin
        e = exp_q.pop_front();
        if (e[26]) t = (e[20:16] == 5'd4) ? "R5 advertise write" :
                       (e[15:0] == 16'h8000) ? "R2 soft reset write" : "R6 negotiation start write";
        else t = (e[20:16] == 5'd0) ? "R3 reset poll read" : "R7/R8 status read";
        chk(t, {5'd0, seen}, {5'd0, e});
      end
      if (gap_due) chk("R3 wait between polls", {31'd0, (cyc - last_done_cyc) >= WAIT}, 32'd1);
      gap_due = 0;
      act = 1;
      lat = 1 + (cyc % 3);
      cur = seen;
    end else if (act) begin
      chk("R10 request held", {4'd0, req_valid, seen}, {4'd0, 1'b1, cur});
    end
    if (act) begin
      lat--;
      if (lat == 0) begin
        act = 0;
        rsp_done = 1;
        last_done_cyc = cyc;
        d = 16'h0;
        if (!cur[26] && cur[20:16] == 5'd0) begin
          d = (rd0_n < sc_rb) ? 16'h9140 : 16'h1140;
          rd0_n++;
          if (d[15]) begin
            gap_due = 1;
            if (rd0_n == RT) begin n_er = 1; n_busy = 0; end
          end
        end else if (!cur[26] && cur[20:16] == 5'd1) begin
          if (!neg_ok) begin
            d = (rd1_n < sc_np) ? 16'h0809 : 16'h082D;
            rd1_n++;
            if (!d[5]) begin
              gap_due = 1;
              if (rd1_n == NT) begin n_en = 1; n_busy = 0; end
            end else neg_ok = 1;
          end else begin
            d = sc_fin;
            n_ok = 1; n_100 = d[14] | d[13]; n_full = d[14] | d[12]; n_busy = 0;
          end
        end
        rsp_rdata = d;
      end
    end
  endtask

  task automatic run(input int rb, input int np, input logic [15:0] fin,
                     input logic [4:0] ad, input int poke);
    int n;
    sc_rb = rb; sc_np = np; sc_fin = fin; phy_addr = ad;
    go = 1; step(); go = 0;
    n = 0;
    while ((n_busy || act) && n < 20000) begin
      if (n == poke) go = 1;   // R11: start while busy
      step();
      go = 0;
      n++;
    end
    if (n >= 20000) chk("R7 scenario watchdog", 32'd1, 32'd0);
    step(); step();
    chk("R4 no missing or extra requests", exp_q.size(), 32'd0);
  endtask

  initial begin
    #1_600_000;
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      // R1: reset state
      chk("R1 reset outputs", {25'd0, busy, link_ok, speed_100, full_duplex, err_r, err_n, req_valid}, 32'd0);
    end
    rst_n = 1'b1;
    step(); step();
    // R10: stray done while idle
    spur = 1; step(); spur = 0; step(); step();
    chk("R10 stray done ignored", {31'd0, req_valid}, 32'd0);
    run(2, 3, 16'h7800, 5'h05, 20);     // 100 full, start poked mid-run
    spur = 1; step(); spur = 0; step(); step();   // R12: results hold
    run(0, 0, 16'h2000, 5'h1A, -1);     // 100 half
    run(1, 1, 16'h1000, 5'h00, -1);     // 10 full
    run(0, 2, 16'h0800, 5'h1F, -1);     // 10 half
    run(RT, 0, 16'h7800, 5'h03, -1);    // R4 reset timeout
    run(RT - 1, NT - 1, 16'h4000, 5'h11, -1);  // last permitted attempts
    run(0, NT, 16'h7800, 5'h07, -1);    // R7 negotiation timeout
    run(0, 0, 16'h6000, 5'h09, 3);      // R11 errors cleared by new start
    step(); step();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule